// File: doc/BRIEF.md
# Undefined Exception Entry Selector

When an instruction turns out to be undefined, or when execution is attempted while the processor is in an illegal state, the core must decide where the exception goes. This block makes that decision. From the current privilege level, the level-2 enable, the route-to-hypervisor control bit and the encoding width of the faulting instruction, it computes:

- the destination mode, which is hypervisor mode or undefined mode;
- the vector offset;
- the link-register offset;
- the preferred return address;
- the syndrome class that is recorded.

A request is presented with a one-cycle strobe. The answer is registered and reported with a one-cycle done pulse. The exception-entry sequencer then uses the registered fields to perform the mode switch, which this block does not do. Illegal-state faults go through the same routing as undefined instructions. They differ only in the syndrome class reported when the exception is bound for the hypervisor.

Top module: `undef_entry_sel`

## Requirements
- R1: While reset is asserted, and right after reset, every output is zero.
- R2: `done` is high for exactly the one cycle after a cycle in which `req_valid` is high, and low after a cycle in which it is low.
- R3: A request made at privilege level 2 (`cur_level` = 2) selects hypervisor mode (`to_hyp` = 1) with vector offset 0x04.
- R4: A request made at level 0 with `lvl2_en` = 1 and `hyp_route` = 1 selects hypervisor mode with vector offset 0x14.
- R5: Any other request selects undefined mode (`to_hyp` = 0) with vector offset 0x04. This covers level 1, level 3, and level 0 with either routing bit clear.
- R6: The link offset is 4 when `narrow_isa` = 0 (32-bit encoding) and 2 when `narrow_isa` = 1 (16-bit encoding).
- R7: The return address equals the `instr_addr` presented with the request.
- R8: The syndrome class is 0x0E (illegal state) when `illegal_st` = 1 and the request is hypervisor-bound. In every other case it is 0x00 (uncategorized).
- R9: Without a strobe, `to_hyp`, `vec_off`, `link_off`, `ret_addr` and `syn_class` hold their last values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle request strobe |
| cur_level | input | 2 | Current privilege level, 0 to 3 |
| lvl2_en | input | 1 | Level 2 is enabled |
| hyp_route | input | 1 | Route level-0 undefined faults to the hypervisor |
| narrow_isa | input | 1 | 1 means the faulting instruction uses the 16-bit encoding |
| illegal_st | input | 1 | The fault comes from illegal execution state |
| instr_addr | input | 32 | Address of the faulting instruction |
| done | output | 1 | Result-valid pulse |
| to_hyp | output | 1 | 1 for hypervisor mode, 0 for undefined mode |
| vec_off | output | 8 | Vector offset |
| link_off | output | 3 | Link-register offset |
| ret_addr | output | 32 | Preferred return address |
| syn_class | output | 6 | Syndrome class: 0x00 uncategorized, 0x0E illegal state |

## Verification
Several properties are checked on every cycle:

- the strobe-to-done timing and the hold of the results between strobes;
- the mapping from level and routing bits to mode and vector;
- the width-dependent link offset;
- the return address being captured unchanged.

Illegal-state faults that stay out of the hypervisor must be shown to lose their special class. That case, together with the exhaustive sweep over levels and routing-bit combinations and back-to-back requests with differing widths, is covered by the directed scenarios.

// File: rtl/undef_entry_pkg.sv
package undef_entry_pkg;
    localparam int unsigned LVL_W      = 2;
    localparam int unsigned VEC_W      = 8;
    localparam int unsigned LINK_W     = 3;
    localparam int unsigned CLS_W      = 6;

    localparam logic [LVL_W-1:0]  LVL_USER = 2'd0;
    localparam logic [LVL_W-1:0]  LVL_HYP  = 2'd2;

    localparam logic [VEC_W-1:0]  VEC_UNDEF    = 8'h04;
    localparam logic [VEC_W-1:0]  VEC_HYPTRAP  = 8'h14;

    localparam logic [LINK_W-1:0] LINK_WIDE    = 3'd4;
    localparam logic [LINK_W-1:0] LINK_NARROW  = 3'd2;

    typedef enum logic [CLS_W-1:0] {
        CLS_UNCAT   = 6'h00,
        CLS_ILLEGAL = 6'h0E
    } syn_class_e;
endpackage

// File: rtl/undef_entry_route.sv
module undef_entry_route
    import undef_entry_pkg::*;
(
    input  logic [LVL_W-1:0] cur_level,
    input  logic             lvl2_en,
    input  logic             hyp_route,
    input  logic             illegal_st,
    output logic             to_hyp,
    output logic [VEC_W-1:0] vec_off,
    output logic [CLS_W-1:0] syn_class
);
    logic at_hyp;
    logic routed;

    always_comb begin
        at_hyp    = (cur_level == LVL_HYP);
        routed    = (cur_level == LVL_USER) && lvl2_en && hyp_route;
        to_hyp    = at_hyp || routed;
        vec_off   = routed ? VEC_HYPTRAP : VEC_UNDEF;
        syn_class = (illegal_st && to_hyp) ? CLS_ILLEGAL : CLS_UNCAT;
    end
endmodule

// File: rtl/undef_entry_link.sv
module undef_entry_link
    import undef_entry_pkg::*;
#(
    parameter bit REGISTER_SEL = 1'b0
) (
    input  logic              narrow_isa,
    output logic [LINK_W-1:0] link_off
);
    generate
        if (REGISTER_SEL) begin : g_mux
            always_comb link_off = narrow_isa ? LINK_NARROW : LINK_WIDE;
        end else begin : g_xor
            always_comb link_off = LINK_WIDE ^ {LINK_W{narrow_isa}} & (LINK_WIDE | LINK_NARROW);
        end
    endgenerate
endmodule

// File: rtl/undef_entry_sel.sv
module undef_entry_sel
    import undef_entry_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [LVL_W-1:0]       cur_level,
    input  logic                   lvl2_en,
    input  logic                   hyp_route,
    input  logic                   narrow_isa,
    input  logic                   illegal_st,
    input  logic [ADDR_W-1:0]      instr_addr,
    output logic                   done,
    output logic                   to_hyp,
    output logic [VEC_W-1:0]       vec_off,
    output logic [LINK_W-1:0]      link_off,
    output logic [ADDR_W-1:0]      ret_addr,
    output logic [CLS_W-1:0]       syn_class
);
    typedef struct packed {
        logic              done;
        logic              to_hyp;
        logic [VEC_W-1:0]  vec;
        logic [LINK_W-1:0] link;
        logic [ADDR_W-1:0] ret;
        logic [CLS_W-1:0]  cls;
    } entry_t;

    entry_t st_d, st_q;

    logic              rt_hyp;
    logic [VEC_W-1:0]  rt_vec;
    logic [CLS_W-1:0]  rt_cls;
    logic [LINK_W-1:0] lk_off;

    undef_entry_route u_route (
        .cur_level (cur_level),
        .lvl2_en   (lvl2_en),
        .hyp_route (hyp_route),
        .illegal_st(illegal_st),
        .to_hyp    (rt_hyp),
        .vec_off   (rt_vec),
        .syn_class (rt_cls)
    );

    undef_entry_link #(.REGISTER_SEL(1'b1)) u_link (
        .narrow_isa(narrow_isa),
        .link_off  (lk_off)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = req_valid;
        if (req_valid) begin
            st_d.to_hyp = rt_hyp;
            st_d.vec    = rt_vec;
            st_d.link   = lk_off;
            st_d.ret    = instr_addr;
            st_d.cls    = rt_cls;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done      = st_q.done;
    assign to_hyp    = st_q.to_hyp;
    assign vec_off   = st_q.vec;
    assign link_off  = st_q.link;
    assign ret_addr  = st_q.ret;
    assign syn_class = st_q.cls;
endmodule

// File: rtl/undef_entry_sel_chk.sv
module undef_entry_sel_chk
    import undef_entry_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [LVL_W-1:0]  cur_level,
    input logic              lvl2_en,
    input logic              hyp_route,
    input logic              narrow_isa,
    input logic [ADDR_W-1:0] instr_addr,
    input logic              done,
    input logic              to_hyp,
    input logic [VEC_W-1:0]  vec_off,
    input logic [LINK_W-1:0] link_off,
    input logic [ADDR_W-1:0] ret_addr,
    input logic [CLS_W-1:0]  syn_class
);
    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> done);
    assert_no_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !done);
    assert_hyp_local_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cur_level == LVL_HYP) |=> (to_hyp && vec_off == VEC_UNDEF));
    assert_hyp_routed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cur_level == LVL_USER && lvl2_en && hyp_route)
        |=> (to_hyp && vec_off == VEC_HYPTRAP));
    assert_undef_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !to_hyp) |-> (vec_off == VEC_UNDEF && syn_class == CLS_UNCAT));
    assert_link_narrow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && narrow_isa) |=> (link_off == LINK_NARROW));
    assert_link_wide_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !narrow_isa) |=> (link_off == LINK_WIDE));
    assert_ret_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (ret_addr == $past(instr_addr)));
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(to_hyp) && $stable(vec_off) && $stable(link_off)
                        && $stable(ret_addr) && $stable(syn_class)));
endmodule

bind undef_entry_sel undef_entry_sel_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .cur_level (cur_level),
    .lvl2_en   (lvl2_en),
    .hyp_route (hyp_route),
    .narrow_isa(narrow_isa),
    .instr_addr(instr_addr),
    .done      (done),
    .to_hyp    (to_hyp),
    .vec_off   (vec_off),
    .link_off  (link_off),
    .ret_addr  (ret_addr),
    .syn_class (syn_class)
);

// File: tb/undef_entry_sel_bench.sv
`timescale 1ns/1ps
module undef_entry_sel_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  cur_level = '0;
    logic        lvl2_en = 1'b0;
    logic        hyp_route = 1'b0;
    logic        narrow_isa = 1'b0;
    logic        illegal_st = 1'b0;
    logic [31:0] instr_addr = '0;
    logic        done, to_hyp;
    logic [7:0]  vec_off;
    logic [2:0]  link_off;
    logic [31:0] ret_addr;
    logic [5:0]  syn_class;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    undef_entry_sel u_undef_entry_sel (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .cur_level(cur_level),
        .lvl2_en(lvl2_en), .hyp_route(hyp_route), .narrow_isa(narrow_isa),
        .illegal_st(illegal_st), .instr_addr(instr_addr), .done(done),
        .to_hyp(to_hyp), .vec_off(vec_off), .link_off(link_off),
        .ret_addr(ret_addr), .syn_class(syn_class)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
            finish_run();
        end
    end

    // One request followed by a check of every registered field against the rules.
    task automatic fire(input logic [1:0] lvl, input logic en, input logic rt,
                        input logic nar, input logic ill, input logic [31:0] addr);
        logic        e_routed = (lvl == 2'd0) && en && rt;
        logic        e_hyp    = (lvl == 2'd2) || e_routed;
        logic [7:0]  e_vec    = e_routed ? 8'h14 : 8'h04;
        logic [5:0]  e_cls    = (ill && e_hyp) ? 6'h0E : 6'h00;
        @(negedge clk);
        cur_level = lvl; lvl2_en = en; hyp_route = rt;
        narrow_isa = nar; illegal_st = ill; instr_addr = addr;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R2", "done pulse", done, 1);
        check(e_routed ? "R4" : (lvl == 2'd2 ? "R3" : "R5"), "to_hyp", to_hyp, e_hyp);
        check(e_routed ? "R4" : (lvl == 2'd2 ? "R3" : "R5"), "vec_off", vec_off, e_vec);
        check("R6", "link_off", link_off, nar ? 3'd2 : 3'd4);
        check("R7", "ret_addr", ret_addr, addr);
        check("R8", "syn_class", syn_class, e_cls);
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", "done", done, 0);
        check("R1", "to_hyp", to_hyp, 0);
        check("R1", "vec_off", vec_off, 0);
        check("R1", "link_off", link_off, 0);
        check("R1", "ret_addr", ret_addr, 0);
        check("R1", "syn_class", syn_class, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "done after release", done, 0);
    endtask

    task automatic test_sweep();
        for (int l = 0; l < 4; l++)
            for (int b = 0; b < 4; b++)
                fire(l[1:0], b[1], b[0], b[0] ^ b[1], 1'b0, 32'h1000_0000 + (l * 16 + b) * 4);
    endtask

    task automatic test_illegal();
        fire(2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0000_8000);
        fire(2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 32'h0000_8002);
        fire(2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 32'h0000_8004);
        fire(2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 32'h0000_8006);
        fire(2'd3, 1'b0, 1'b1, 1'b0, 1'b1, 32'h0000_8008);
    endtask

    task automatic test_hold();
        fire(2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 32'hCAFE_0002);
        cur_level = 2'd1; lvl2_en = 1'b0; hyp_route = 1'b0;
        narrow_isa = 1'b0; illegal_st = 1'b0; instr_addr = 32'h1234_5678;
        repeat (3) @(negedge clk);
        check("R2", "done after idle", done, 0);
        check("R9", "to_hyp held", to_hyp, 1);
        check("R9", "vec_off held", vec_off, 8'h14);
        check("R9", "link_off held", link_off, 3'd2);
        check("R9", "ret_addr held", ret_addr, 32'hCAFE_0002);
        check("R9", "syn_class held", syn_class, 6'h0E);
    endtask

    task automatic test_back_to_back();
        @(negedge clk);
        cur_level = 2'd2; narrow_isa = 1'b0; illegal_st = 1'b0;
        instr_addr = 32'hA000_0000; req_valid = 1'b1;
        @(negedge clk);
        check("R2", "b2b first done", done, 1);
        check("R6", "b2b first link", link_off, 3'd4);
        cur_level = 2'd1; narrow_isa = 1'b1; instr_addr = 32'hA000_0002;
        @(negedge clk);
        req_valid = 1'b0;
        check("R2", "b2b second done", done, 1);
        check("R5", "b2b second to_hyp", to_hyp, 0);
        check("R6", "b2b second link", link_off, 3'd2);
        check("R7", "b2b second ret", ret_addr, 32'hA000_0002);
        @(negedge clk);
        check("R2", "b2b done drops", done, 0);
    endtask

    initial begin
        test_reset();
        test_sweep();
        test_illegal();
        test_hold();
        test_back_to_back();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule